// File: doc/BRIEF.md
# Single-Wire Bus Slot Master

This block produces the timed bus slots for an open-drain, single-wire serial bus from a fixed system clock. A controller hands it one request at a time: a bus reset with presence detection, a write of a 0 bit, a write of a 1 bit, or a read of one bit. The block pulls the line low for the right length of time, releases it, samples the line where needed, and then reports completion. Byte assembly, device addressing and integrity checks are left to the layer above.

All timing is counted in microseconds. A prescaler divides the clock into microsecond ticks, and `CLK_PER_US` sets how many clock cycles make one tick. In a read slot the master holds the line low only briefly and samples late in the first 15 µs of the slot. This leaves the most room for a slow rising edge. The line input passes through a two-flop synchroniser before it is sampled.

A separate enable output drives a strong pullup. When the controller asks for it along with a request, this output switches on as the slot ends. It stays on until the next request is accepted, so that a parasitically powered device on the bus has a current supply. It is never on while the block pulls the line low.

Top module: `swire_slot_master`

## Requirements
- R1: While `rst_n` is low and right after it rises, `busy`, `done`, `bus_drive_low`, `spu_en`, `rx_bit` and `presence` are all 0.
- R2: A request is accepted only when `cmd_valid` is 1 and `busy` is 0, with `cmd_op` encoded as 00 reset, 01 write 0, 10 write 1, 11 read. `busy` and `bus_drive_low` both rise on the accepting clock edge. A `cmd_valid` seen while `busy` is 1 is ignored and alters neither the slot in progress nor what follows it.
- R3: A write-0 slot holds the line low for 60 µs. A write-1 slot holds it low for 2 µs. Every write or read slot keeps `busy` high for 65 µs in total.
- R4: A read slot holds the line low for 2 µs and samples the synchronised line at 13 µs after the slot starts. `rx_bit` takes the value sampled (1 = line high) and holds it through later non-read slots.
- R5: A reset holds the line low for 480 µs and samples the line 70 µs after release. `presence` is set to 1 if the line is low at that point and 0 otherwise. `busy` stays high for 960 µs in total.
- R6: `done` is a single-cycle pulse issued on the same edge at which `busy` falls, once per accepted request.
- R7: `bus_drive_low` is never 1 while `busy` is 0.
- R8: If `cmd_spu` was 1 when a request was accepted, `spu_en` rises with `done` and stays high until the next accepted request, which clears it on its accepting edge. Otherwise `spu_en` stays 0. `spu_en` is 0 whenever `busy` or `bus_drive_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe, taken when idle |
| cmd_op | input | 2 | 00 reset, 01 write 0, 10 write 1, 11 read |
| cmd_spu | input | 1 | Enable strong pullup after this slot |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Bit sampled by the last read slot |
| presence | output | 1 | Presence result of the last reset |
| bus_drive_low | output | 1 | Pull the bus line low (open-drain control) |
| bus_in | input | 1 | Raw bus line level |
| spu_en | output | 1 | Strong pullup enable |

## Verification
The assertions check on every cycle that the line is only pulled low during a slot, that each slot starts low on its accepting edge, that `done` is a lone pulse on the falling edge of `busy`, and that the strong pullup never overlaps a low drive and only drops when a new request starts. The actual slot lengths, the place of the read sample and the presence sample, and the value of `rx_bit` and `presence` against a modelled device that pulls the line low at chosen moments can only be shown by the bench scenarios. Those scenarios include presence pulses that end just before or start just after the sample point, and requests that arrive while a slot is running.

// File: rtl/swire_slot_master.sv
module swire_slot_master #(
  parameter int CLK_PER_US     = 200,
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RST_TOTAL_US   = 960,
  parameter int SLOT_US        = 65,
  parameter int W0_LOW_US      = 60,
  parameter int SHORT_LOW_US   = 2,
  parameter int RD_SAMPLE_US   = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_spu,
  output logic       busy,
  output logic       done,
  output logic       rx_bit,
  output logic       presence,
  output logic       bus_drive_low,
  input  logic       bus_in,
  output logic       spu_en
);
  localparam int UW = $clog2(RST_TOTAL_US + 1);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [1:0] OP_RESET = 2'b00;
  localparam logic [1:0] OP_W0    = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b11;

  logic [1:0]    sync_q;
  logic          busy_q, done_q, drv_q, spu_q, spu_arm_q, rx_q, pres_q;
  logic [1:0]    op_q;
  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;
  logic [UW-1:0] low_us, end_us;

  wire           tick  = busy_q && (pre_q == PW'(CLK_PER_US - 1));
  wire [UW-1:0]  us_nx = us_q + UW'(1);

  always_comb begin
    case (op_q)
      OP_RESET: low_us = UW'(RST_LOW_US);
      OP_W0:    low_us = UW'(W0_LOW_US);
      default:  low_us = UW'(SHORT_LOW_US);
    endcase
    end_us = (op_q == OP_RESET) ? UW'(RST_TOTAL_US) : UW'(SLOT_US);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      drv_q     <= 1'b0;
      spu_q     <= 1'b0;
      spu_arm_q <= 1'b0;
      rx_q      <= 1'b0;
      pres_q    <= 1'b0;
      op_q      <= 2'b00;
      pre_q     <= '0;
      us_q      <= '0;
    end else begin
      sync_q <= {sync_q[0], bus_in};
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid) begin
          busy_q    <= 1'b1;
          op_q      <= cmd_op;
          spu_arm_q <= cmd_spu;
          pre_q     <= '0;
          us_q      <= '0;
          drv_q     <= 1'b1;
          spu_q     <= 1'b0;
        end
      end else begin
        pre_q <= tick ? '0 : pre_q + PW'(1);
        if (tick) begin
          us_q <= us_nx;
          if (us_nx == low_us)
            drv_q <= 1'b0;
          if (op_q == OP_READ && us_nx == UW'(RD_SAMPLE_US))
            rx_q <= sync_q[1];
          if (op_q == OP_RESET && us_nx == UW'(RST_LOW_US + PRES_SAMPLE_US))
            pres_q <= ~sync_q[1];
          if (us_nx == end_us) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            spu_q  <= spu_arm_q;
          end
        end
      end
    end
  end

  assign busy          = busy_q;
  assign done          = done_q;
  assign rx_bit        = rx_q;
  assign presence      = pres_q;
  assign bus_drive_low = drv_q;
  assign spu_en        = spu_q;
endmodule

module swire_slot_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic drv,
  input logic spu
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !drv); // R7
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> drv); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) !(drv && spu)); // R8
  AST_SPU_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) spu |-> !busy); // R8
  AST_SPU_DROP_ON_START: assert property (@(posedge clk) disable iff (!rst_n) $fell(spu) |-> $rose(busy)); // R8
endmodule

bind swire_slot_master swire_slot_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .drv(bus_drive_low), .spu(spu_en)
);

// File: tb/swire_slot_master_tb_top.sv
`timescale 1ns/1ps
module swire_slot_master_tb_top;
  localparam int CPU = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_spu = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic busy, done, rx_bit, presence, drv, spu_en, bus_in;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int busy_cnt = 0, low_cnt = 0, done_cnt = 0, clash_cnt = 0;
  int s_cyc = 0, e_cyc = 0;
  bit mon_on = 1'b0, finished = 1'b0;
  bit exp_rx = 1'b0;

  wire slave_low = busy && (busy_cnt >= s_cyc) && (busy_cnt < e_cyc);
  assign bus_in = !(drv || slave_low);

  always #2.5 clk = ~clk;

  swire_slot_master #(.CLK_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_spu(cmd_spu),
    .busy(busy), .done(done), .rx_bit(rx_bit), .presence(presence),
    .bus_drive_low(drv), .bus_in(bus_in), .spu_en(spu_en)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    if (mon_on) begin
      if (busy) busy_cnt++;
      if (drv) low_cnt++;
      if (done) done_cnt++;
    end
    if (drv && spu_en) clash_cnt++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_low_us(input logic [1:0] op);
    case (op)
      2'b00: return 480;
      2'b01: return 60;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_total_us(input logic [1:0] op);
    return (op == 2'b00) ? 960 : 65;
  endfunction

  // device pulls low over [s_us, e_us); sample points at 13 us (read) and 550 us (reset)
  function automatic bit exp_line_high(input int s_us, input int e_us, input int at_us);
    return !(s_us < at_us && e_us > at_us);
  endfunction

  task automatic run(input logic [1:0] op, input bit spu, input int s_us, input int e_us, input bit inject);
    bit exp_pres;
    int pr_rx;
    string rq;
    pr_rx = rx_bit;
    busy_cnt = 0; low_cnt = 0; done_cnt = 0;
    s_cyc = s_us * CPU; e_cyc = e_us * CPU;
    mon_on = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_spu = spu;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_spu = 1'b0;
    chk(busy && drv && !spu_en, "R2", "busy/low/spu on start", {busy, drv, spu_en}, 3'b110);
    if (inject) begin
      repeat (20) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = ~op; cmd_spu = ~spu;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_spu = 1'b0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
    @(negedge clk);
    mon_on = 1'b0;
    rq = (op == 2'b00) ? "R5" : (op == 2'b11) ? "R4" : "R3";
    chk(low_cnt == exp_low_us(op) * CPU, rq, "low cycles", low_cnt, exp_low_us(op) * CPU);
    chk(busy_cnt == exp_total_us(op) * CPU, rq, "busy cycles", busy_cnt, exp_total_us(op) * CPU);
    chk(done_cnt == 1, "R6", "done pulses", done_cnt, 1);
    chk(!busy && !drv, "R7", "idle after slot, no restart", {busy, drv}, 0);
    chk(spu_en == spu, "R8", "spu_en held after slot", spu_en, spu);
    if (op == 2'b11) begin
      exp_rx = exp_line_high(s_us, e_us, 13);
      chk(rx_bit == exp_rx, "R4", "rx_bit", rx_bit, exp_rx);
    end else begin
      chk(rx_bit == pr_rx, "R4", "rx_bit held", rx_bit, pr_rx);
    end
    if (op == 2'b00) begin
      exp_pres = !exp_line_high(s_us, e_us, 550);
      chk(presence == exp_pres, "R5", "presence", presence, exp_pres);
    end
    if (inject)
      chk(busy_cnt == exp_total_us(op) * CPU && !busy, "R2", "request during slot ignored", busy_cnt, exp_total_us(op) * CPU);
  endtask

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    chk({busy, done, drv, spu_en, rx_bit, presence} == 6'b0, "R1", "outputs in reset",
        {busy, done, drv, spu_en, rx_bit, presence}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, drv, spu_en, rx_bit, presence} == 6'b0, "R1", "outputs after reset",
        {busy, done, drv, spu_en, rx_bit, presence}, 0);

    run(2'b00, 1'b0, 490, 600, 1'b0);   // presence seen
    run(2'b00, 1'b0, 485, 540, 1'b0);   // pulse ends before sample
    run(2'b00, 1'b1, 560, 700, 1'b0);   // pulse starts after sample
    run(2'b11, 1'b0, 1, 15, 1'b0);      // device holds low past sample: 0
    run(2'b11, 1'b0, 1, 11, 1'b0);      // device releases before sample: 1
    run(2'b01, 1'b1, 0, 0, 1'b1);       // write 0, ignored request mid slot
    run(2'b10, 1'b0, 0, 0, 1'b0);
    chk(clash_cnt == 0, "R8", "spu and low never together", clash_cnt, 0);

    for (int i = 0; i < 30; i++) begin
      logic [1:0] op;
      int s, e;
      bit spu, inj;
      op  = 2'($urandom % 4);
      spu = 1'($urandom % 2);
      inj = ($urandom % 4) == 0;
      s = 0; e = 0;
      if (op == 2'b11 && ($urandom % 2) == 1) begin s = 1; e = 15 + int'($urandom % 15); end
      if (op == 2'b00 && ($urandom % 3) != 0) begin s = 485 + int'($urandom % 40); e = 560 + int'($urandom % 150); end
      run(op, spu, s, e, inj);
    end
    chk(clash_cnt == 0, "R8", "spu and low never together (random)", clash_cnt, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule